// File: doc/BRIEF.md
# Conversion Result Ready Controller

This block sits between a conversion engine that produces result words at a steady rate and a serial host that collects them. It keeps the most recent result in a data register and drives an active-low ready output that tells the host a fresh word is waiting. Reading a complete word releases the ready output. A completed calibration pulls it low in the same way.

Before each register update the converter raises a pre-update request. The block then holds ready inactive for a fixed window of `BLANK_CYC` master-clock cycles and loads the new word only once the window has run out. This way the host never starts a read while the register is being overwritten. An update strobe that arrives during the window is held and loaded when the window ends. A strobe that arrives after the window is loaded at once. A status bit gives the host the ready level without using the pin. Reset is asynchronous and active-low, and is released through a two-stage synchronizer.

Top module: `cvt_ready_ctrl`

## Requirements
- R1: Two clock edges after reset is released, `ready_n` and `rdy_flag` are 1 and `data_q` is zero. They stay that way until the first update or calibration-done event.
- R2: With no window open, an `upd_stb` sampled on a clock edge loads `upd_word` into `data_q` at that edge and drives `ready_n` to 0 from that edge.
- R3: An `rd_done` sampled while `ready_n` is 0 drives `ready_n` to 1 at that edge and leaves `data_q` unchanged.
- R4: An `rd_done` sampled while `ready_n` is already 1 has no effect: `ready_n` stays 1 and `data_q` is unchanged.
- R5: When no window is open, a `pre_req` sampled at edge E0 opens a window. `ready_n` is 1 from E0 on, and no load takes place before edge E0+`BLANK_CYC`.
- R6: An `upd_stb` sampled at edge E0+d, where d > `BLANK_CYC`, loads its word at that edge and drives `ready_n` to 0.
- R7: An `upd_stb` sampled at an edge from E0+1 through E0+`BLANK_CYC` has its word loaded at edge E0+`BLANK_CYC`. If several strobes fall inside the window, the last one wins.
- R8: A `cal_done` sampled while no window is open drives `ready_n` to 0 and leaves `data_q` unchanged. While a window is open, `ready_n` stays 1.
- R9: `rdy_flag` always carries the same level as `ready_n` (1 = not ready).
- R10: A `pre_req` sampled while a window is already open is ignored and does not restart the count.
- R11: When `rd_done` and `cal_done` are sampled at the same edge with no window open, `ready_n` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_req | input | 1 | Converter request to open the blanking window |
| upd_stb | input | 1 | Converter strobe: `upd_word` is a new result |
| upd_word | input | DATA_W | New result word |
| cal_done | input | 1 | Calibration-finished strobe |
| rd_done | input | 1 | Host has finished reading a complete word |
| ready_n | output | 1 | Active-low data-ready output |
| rdy_flag | output | 1 | Status copy of the ready level |
| data_q | output | DATA_W | Data register contents |

## Verification
The assertions assume the three strobes are single-cycle pulses sampled on the master clock. They also assume that a read-complete and an update strobe never coincide in a way the properties exclude. The properties name the strobe combinations they do not cover, and stay silent in those cases. The stimulus drives every strobe for exactly one cycle, changing it on the falling edge. It sweeps the update strobe's offset from the window request across the cases of inside, at the end of, and after the window, using a shortened window. Concurrent strobes appear only in the directed cases that target them.

// File: rtl/cvt_rdy_pkg.sv
package cvt_rdy_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_BLANK = 2'd1,
    WIN_ARMED = 2'd2
  } win_state_e;
endpackage

// File: rtl/cvt_rst_sync.sv
module cvt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cvt_blank_timer.sv
module cvt_blank_timer #(
  parameter int BLANK_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (BLANK_CYC > 2) ? $clog2(BLANK_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign done = busy_q && (cnt_q == LAST);
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/cvt_result_reg.sv
module cvt_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              ld_en,
  input  logic              ld_pend,
  input  logic [DATA_W-1:0] live_word,
  output logic [DATA_W-1:0] data_q,
  output logic              pend_vld
);
  logic [DATA_W-1:0] pend_q, pend_d, data_d;
  logic              vld_q, vld_d;

  always_comb begin
    pend_d = pend_q;
    vld_d  = vld_q;
    data_d = data_q;
    if (ld_en) begin
      data_d = ld_pend ? pend_q : live_word;
      vld_d  = 1'b0;
    end else if (cap_en) begin
      pend_d = live_word;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign pend_vld = vld_q;
endmodule

// File: rtl/cvt_ready_ctrl.sv
module cvt_ready_ctrl
  import cvt_rdy_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLANK_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_req,
  input  logic              upd_stb,
  input  logic [DATA_W-1:0] upd_word,
  input  logic              cal_done,
  input  logic              rd_done,
  output logic              ready_n,
  output logic              rdy_flag,
  output logic [DATA_W-1:0] data_q
);
  logic       rst_sync_n;
  win_state_e win_q, win_d;
  logic       blk_start, blk_busy, blk_done;
  logic       ld_en, ld_pend, cap_en, pend_vld;
  logic       rdy_n_q, rdy_n_d;
  logic       win_open;

  cvt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cvt_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (blk_start),
    .busy  (blk_busy),
    .done  (blk_done)
  );

  cvt_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cap_en    (cap_en),
    .ld_en     (ld_en),
    .ld_pend   (ld_pend),
    .live_word (upd_word),
    .data_q    (data_q),
    .pend_vld  (pend_vld)
  );

  always_comb begin
    win_d     = win_q;
    ld_en     = 1'b0;
    ld_pend   = 1'b0;
    cap_en    = 1'b0;
    blk_start = 1'b0;
    unique case (win_q)
      WIN_IDLE: begin
        if (upd_stb) ld_en = 1'b1;
        if (pre_req) begin
          win_d     = WIN_BLANK;
          blk_start = 1'b1;
        end
      end
      WIN_BLANK: begin
        if (blk_done) begin
          if (upd_stb) begin
            ld_en = 1'b1;
          end else if (pend_vld) begin
            ld_en   = 1'b1;
            ld_pend = 1'b1;
          end
          win_d = (upd_stb || pend_vld) ? WIN_IDLE : WIN_ARMED;
        end else if (upd_stb) begin
          cap_en = 1'b1;
        end
      end
      WIN_ARMED: begin
        if (upd_stb) begin
          ld_en = 1'b1;
          win_d = WIN_IDLE;
        end
      end
      default: win_d = WIN_IDLE;
    endcase
  end

  always_comb begin
    rdy_n_d = rdy_n_q;
    if (rd_done)           rdy_n_d = 1'b1;
    if (cal_done)          rdy_n_d = 1'b0;
    if (ld_en)             rdy_n_d = 1'b0;
    if (win_d != WIN_IDLE) rdy_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      win_q   <= WIN_IDLE;
      rdy_n_q <= 1'b1;
    end else begin
      win_q   <= win_d;
      rdy_n_q <= rdy_n_d;
    end
  end

  assign win_open = (win_q != WIN_IDLE);
  assign ready_n  = rdy_n_q;
  assign rdy_flag = rdy_n_q;
endmodule

// File: rtl/cvt_ready_ctrl_chk.sv
module cvt_ready_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pre_req,
  input logic              upd_stb,
  input logic              cal_done,
  input logic              rd_done,
  input logic              ready_n,
  input logic [DATA_W-1:0] data_q,
  input logic              win_open,
  input logic              blk_busy
);
  assert_load_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_q) && !win_open) |-> !ready_n);

  assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !ready_n && !cal_done && !upd_stb && !pre_req) |=> ready_n);

  assert_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && ready_n && !cal_done && !upd_stb && !win_open)
      |=> (ready_n && $stable(data_q)));

  assert_blank_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_busy |-> ready_n);

  assert_cal_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !win_open && !pre_req) |=> !ready_n);
endmodule

bind cvt_ready_ctrl cvt_ready_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pre_req  (pre_req),
  .upd_stb  (upd_stb),
  .cal_done (cal_done),
  .rd_done  (rd_done),
  .ready_n  (ready_n),
  .data_q   (data_q),
  .win_open (win_open),
  .blk_busy (blk_busy)
);

// File: tb/cvt_ready_ctrl_bench.sv
module cvt_ready_ctrl_bench;
  localparam int DW  = 8;
  localparam int BLK = 8;

  logic          clk;
  logic          rst_n;
  logic          pre_req, upd_stb, cal_done, rd_done;
  logic [DW-1:0] upd_word;
  logic          ready_n, rdy_flag;
  logic [DW-1:0] data_q;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DW-1:0] exp_data;

  cvt_ready_ctrl #(.DATA_W(DW), .BLANK_CYC(BLK)) u_cvt_ready_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_req  (pre_req),
    .upd_stb  (upd_stb),
    .upd_word (upd_word),
    .cal_done (cal_done),
    .rd_done  (rd_done),
    .ready_n  (ready_n),
    .rdy_flag (rdy_flag),
    .data_q   (data_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic exp_r, input logic [DW-1:0] exp_d);
    chk(ready_n === exp_r, req, int'(ready_n), int'(exp_r));
    chk(data_q === exp_d, req, int'(data_q), int'(exp_d));
    chk(rdy_flag === ready_n, "R9", int'(rdy_flag), int'(ready_n));
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    pre_req = 0; upd_stb = 0; cal_done = 0; rd_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    pre_req = 0; upd_stb = 0; cal_done = 0; rd_done = 0; upd_word = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    exp_data = '0;
    chk_state("R1", 1'b1, '0);

    // R4: read while not ready
    rd_done = 1; tick();
    chk_state("R4", 1'b1, exp_data);

    // R2: unannounced update with no window open
    upd_stb = 1; upd_word = 8'h5C; tick();
    exp_data = 8'h5C;
    chk_state("R2", 1'b0, exp_data);

    // R3: read completes
    rd_done = 1; tick();
    chk_state("R3", 1'b1, exp_data);
    rd_done = 1; tick();
    chk_state("R4", 1'b1, exp_data);

    // R8: calibration done while idle
    cal_done = 1; tick();
    chk_state("R8", 1'b0, exp_data);
    rd_done = 1; tick();
    chk_state("R3", 1'b1, exp_data);

    // R11: read and calibration together
    rd_done = 1; cal_done = 1; tick();
    chk_state("R11", 1'b0, exp_data);

    // R5/R6/R7: sweep update offset relative to the window request
    for (int d = 1; d <= BLK + 4; d++) begin
      logic [DW-1:0] w;
      int lpt;
      w = DW'(d * 7 + 3);
      lpt = (d > BLK) ? d : BLK;
      pre_req = 1; tick();
      chk_state("R5", 1'b1, exp_data);
      for (int k = 1; k <= lpt + 1; k++) begin
        if (k == d) begin upd_stb = 1; upd_word = w; end
        tick();
        if (k < lpt) chk_state("R5", 1'b1, exp_data);
        else chk_state((d > BLK) ? "R6" : "R7", 1'b0, w);
      end
      exp_data = w;
      rd_done = 1; tick();
      chk_state("R3", 1'b1, exp_data);
    end

    // R7: last strobe inside the window wins
    pre_req = 1; tick();
    for (int k = 1; k <= BLK; k++) begin
      if (k == 2) begin upd_stb = 1; upd_word = 8'hA1; end
      if (k == 5) begin upd_stb = 1; upd_word = 8'hB2; end
      tick();
      if (k < BLK) chk_state("R7", 1'b1, exp_data);
    end
    exp_data = 8'hB2;
    chk_state("R7", 1'b0, exp_data);
    rd_done = 1; tick();

    // R10: second request inside window is ignored; R8: calibration blanked
    pre_req = 1; tick();
    for (int k = 1; k <= BLK; k++) begin
      if (k == 1) begin upd_stb = 1; upd_word = 8'h3E; end
      if (k == 3) pre_req = 1;
      if (k == 4) cal_done = 1;
      tick();
      if (k < BLK) chk_state((k == 4) ? "R8" : "R10", 1'b1, exp_data);
    end
    exp_data = 8'h3E;
    chk_state("R10", 1'b0, exp_data);

    // R1: reset mid-operation
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_state("R1", 1'b1, '0);

    report();
  end
endmodule